// File: doc/BRIEF.md
# Two-Level Warp Issue Scheduler

This block chooses, every clock, which warp of a multithreaded SIMT core issues its next instruction. Two pools of warps are tracked. The outer pool is every resident warp, and it includes warps parked on a long-latency result such as a texture fetch or a global-memory load. The inner pool is a small set of slots. Only warps placed in those slots may issue. A warp whose next instruction is tagged as long-latency issues that instruction and leaves its slot in the same cycle. A pulse carrying its warp number goes out so that a register cache can write back that warp's entries. The freed slot is refilled from the outer pool by the lowest-numbered warp that is neither active nor waiting on an outstanding long operation.

Inside the inner pool the choice is greedy. The warp that issued last keeps the grant for as long as its ready flag stays high. Only when it stalls does the lowest-numbered slot holding a ready warp take over. A short-latency stall, such as waiting on an ALU or shared-memory result, never demotes a warp, however long it lasts. The surrounding core supplies the per-warp ready flags, the per-warp latency class of the next instruction, and completion events for long operations.

Top module: `warp_issue_sched`

## Requirements
- R1: While reset is held, no grant, eviction or promotion is signalled. After release, the empty slots are filled at one promotion per cycle, in ascending warp order starting from warp 0, and promotion stops once all ACTIVE_SLOTS slots (6 to 8) are occupied.
- R2: At most one warp is granted per cycle, and only a warp that occupies an inner-pool slot and has its ready flag high. A ready warp in the outer pool is never granted.
- R3: A warp that was granted in the previous cycle, was not evicted, and is still ready is granted again. Other ready warps do not take the grant from it.
- R4: When the previously granted warp is not ready, the grant goes to the ready warp held in the lowest-numbered slot.
- R5: A warp that holds its ready flag low for 20 or more cycles stays in the inner pool and issues as soon as it is ready again, with no eviction pulse.
- R6: When a granted warp's latency-class flag is 1 (long latency), the eviction pulse rises in the same cycle and carries that warp's number. From the next cycle the warp leaves its slot and cannot be granted.
- R7: A free slot is filled in the cycle after it frees up, with the lowest-numbered warp that is neither in the inner pool nor waiting on a long operation.
- R8: An evicted warp stays ineligible for promotion until a completion event naming it is seen. From the next cycle it is eligible again. A completion event for a warp that is not waiting has no effect.
- R9: At most one eviction and one promotion occur per cycle, and the warp evicted in a cycle is never the one promoted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| warpReady | input | NUM_WARPS | Per-warp flag: next instruction can issue now |
| warpLongOp | input | NUM_WARPS | Per-warp latency class of next instruction, 1 = long |
| longDone | input | 1 | Completion event for a long operation |
| longDoneId | input | $clog2(NUM_WARPS) | Warp that the completion event names |
| issueValid | output | 1 | A warp is granted this cycle |
| issueId | output | $clog2(NUM_WARPS) | Granted warp |
| evictValid | output | 1 | Granted warp leaves the inner pool |
| evictId | output | $clog2(NUM_WARPS) | Evicted warp, for the register cache flush |
| promoteValid | output | 1 | A warp enters the inner pool |
| promoteId | output | $clog2(NUM_WARPS) | Promoted warp |

## Verification
The assertions check on every cycle that grants name only slot-resident warps and that the slot count is never exceeded. They also check that no warp is both active and waiting, that a promoted warp was eligible, that eviction lines up with a long-class grant, and that the greedy hold is kept. Whether promotions go to the lowest eligible warp, whether a 20-cycle short stall leaves a warp in place, and whether a completion makes an evicted warp promotable again only show up in the bench. Each of these depends on a history of events, and the bench drives that history in directed scenarios and compares the outputs against warp numbers it works out in advance.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  // Fixed field widths for the control-to-datapath strobe bundle.
  localparam int MAX_WARP_W = 8;  // up to 256 resident warps
  localparam int MAX_SLOT_W = 3;  // up to 8 inner-pool slots

  typedef struct packed {
    logic                  issueEn;
    logic [MAX_SLOT_W-1:0] issueSlot;
    logic                  demoteEn;
    logic                  promoteEn;
    logic [MAX_SLOT_W-1:0] promoteSlot;
    logic [MAX_WARP_W-1:0] promoteWarp;
  } sched_strobe_t;
endpackage

// File: rtl/wsched_ctrl.sv
module wsched_ctrl
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS    = 16,
  parameter int ACTIVE_SLOTS = 6,
  parameter int WID_W        = $clog2(NUM_WARPS),
  parameter int SID_W        = $clog2(ACTIVE_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] warpReady,
  input  logic [NUM_WARPS-1:0] warpLongOp,
  input  logic                 slotValid [ACTIVE_SLOTS],
  input  logic [WID_W-1:0]     slotWarp  [ACTIVE_SLOTS],
  input  logic [NUM_WARPS-1:0] activeQ,
  input  logic [NUM_WARPS-1:0] pendingQ,
  output sched_strobe_t        strobe,
  output logic [WID_W-1:0]     issueWarp
);
  logic [ACTIVE_SLOTS-1:0] slotReady;
  logic                    curValidQ;
  logic [SID_W-1:0]        curSlotQ;
  logic                    anyReady;
  logic [SID_W-1:0]        lowReadySlot;
  logic [SID_W-1:0]        selSlot;
  logic                    anyFree;
  logic [SID_W-1:0]        freeSlot;
  logic                    anyElig;
  logic [WID_W-1:0]        eligWarp;
  logic                    issueEn;
  logic                    demoteEn;

  for (genvar g = 0; g < ACTIVE_SLOTS; g++) begin : gSlotReady
    assign slotReady[g] = slotValid[g] && warpReady[slotWarp[g]];
  end

  // Lowest-numbered ready slot, used when the greedy holder stalls.
  always_comb begin
    anyReady     = 1'b0;
    lowReadySlot = '0;
    for (int s = ACTIVE_SLOTS - 1; s >= 0; s--) begin
      if (slotReady[s]) begin
        anyReady     = 1'b1;
        lowReadySlot = SID_W'(s);
      end
    end
  end

  // Lowest free slot and lowest eligible outer-pool warp.
  always_comb begin
    anyFree  = 1'b0;
    freeSlot = '0;
    for (int s = ACTIVE_SLOTS - 1; s >= 0; s--) begin
      if (!slotValid[s]) begin
        anyFree  = 1'b1;
        freeSlot = SID_W'(s);
      end
    end
    anyElig  = 1'b0;
    eligWarp = '0;
    for (int w = NUM_WARPS - 1; w >= 0; w--) begin
      if (!activeQ[w] && !pendingQ[w]) begin
        anyElig  = 1'b1;
        eligWarp = WID_W'(w);
      end
    end
  end

  // Greedy selection: stay on the last issuer while it is ready.
  always_comb begin
    if (curValidQ && slotReady[curSlotQ]) selSlot = curSlotQ;
    else                                  selSlot = lowReadySlot;
    issueEn   = rstN && anyReady;
    issueWarp = slotWarp[selSlot];
    demoteEn  = issueEn && warpLongOp[issueWarp];
  end

  always_comb begin
    strobe             = '0;
    strobe.issueEn     = issueEn;
    strobe.issueSlot   = MAX_SLOT_W'(selSlot);
    strobe.demoteEn    = demoteEn;
    strobe.promoteEn   = rstN && anyFree && anyElig;
    strobe.promoteSlot = MAX_SLOT_W'(freeSlot);
    strobe.promoteWarp = MAX_WARP_W'(eligWarp);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curValidQ <= 1'b0;
      curSlotQ  <= '0;
    end else if (issueEn) begin
      curValidQ <= !demoteEn;
      curSlotQ  <= selSlot;
    end
  end

  // R4: a change of holder only happens when the holder is not ready
  assert_switch_on_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (issueEn && curValidQ && selSlot != curSlotQ) |-> !slotReady[curSlotQ]);
endmodule

// File: rtl/wsched_dp.sv
module wsched_dp
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS    = 16,
  parameter int ACTIVE_SLOTS = 6,
  parameter int WID_W        = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sched_strobe_t        strobe,
  input  logic [WID_W-1:0]     issueWarp,
  input  logic                 longDone,
  input  logic [WID_W-1:0]     longDoneId,
  output logic                 slotValid [ACTIVE_SLOTS],
  output logic [WID_W-1:0]     slotWarp  [ACTIVE_SLOTS],
  output logic [NUM_WARPS-1:0] activeQ,
  output logic [NUM_WARPS-1:0] pendingQ
);
  logic [WID_W-1:0] promoteWarp;
  assign promoteWarp = strobe.promoteWarp[WID_W-1:0];

  for (genvar g = 0; g < ACTIVE_SLOTS; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotValid[g] <= 1'b0;
        slotWarp[g]  <= '0;
      end else if (strobe.promoteEn && strobe.promoteSlot == MAX_SLOT_W'(g)) begin
        slotValid[g] <= 1'b1;
        slotWarp[g]  <= promoteWarp;
      end else if (strobe.demoteEn && strobe.issueSlot == MAX_SLOT_W'(g)) begin
        slotValid[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ  <= '0;
      pendingQ <= '0;
    end else begin
      if (longDone && pendingQ[longDoneId]) pendingQ[longDoneId] <= 1'b0;
      if (strobe.demoteEn) begin
        activeQ[issueWarp]  <= 1'b0;
        pendingQ[issueWarp] <= 1'b1;
      end
      if (strobe.promoteEn) activeQ[promoteWarp] <= 1'b1;
    end
  end

  // R1: the inner pool never holds more warps than it has slots
  assert_pool_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones(activeQ) <= ACTIVE_SLOTS);
  // R2: a grant always targets an occupied slot
  assert_issue_in_pool_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueEn |-> (slotValid[strobe.issueSlot] && activeQ[issueWarp]));
  // R8: a waiting warp is never in the inner pool
  assert_wait_not_active_R8: assert property (@(posedge clk) disable iff (!rstN)
    (activeQ & pendingQ) == '0);
  // R7: the promoted warp was eligible and the target slot free
  assert_promote_eligible_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.promoteEn |-> (!activeQ[promoteWarp] && !pendingQ[promoteWarp]
                          && !slotValid[strobe.promoteSlot]));
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wsched_pkg::*;
#(
  parameter int NUM_WARPS    = 16,  // resident warps, at most 256
  parameter int ACTIVE_SLOTS = 6,   // inner-pool size, 6 to 8
  localparam int WID_W       = $clog2(NUM_WARPS),
  localparam int SID_W       = $clog2(ACTIVE_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_WARPS-1:0] warpReady,
  input  logic [NUM_WARPS-1:0] warpLongOp,
  input  logic                 longDone,
  input  logic [WID_W-1:0]     longDoneId,
  output logic                 issueValid,
  output logic [WID_W-1:0]     issueId,
  output logic                 evictValid,
  output logic [WID_W-1:0]     evictId,
  output logic                 promoteValid,
  output logic [WID_W-1:0]     promoteId
);
  sched_strobe_t        strobe;
  logic [WID_W-1:0]     issueWarp;
  logic                 slotValid [ACTIVE_SLOTS];
  logic [WID_W-1:0]     slotWarp  [ACTIVE_SLOTS];
  logic [NUM_WARPS-1:0] activeQ;
  logic [NUM_WARPS-1:0] pendingQ;

  wsched_ctrl #(.NUM_WARPS(NUM_WARPS), .ACTIVE_SLOTS(ACTIVE_SLOTS),
                .WID_W(WID_W), .SID_W(SID_W)) uCtrl (
    .clk(clk), .rstN(rstN), .warpReady(warpReady), .warpLongOp(warpLongOp),
    .slotValid(slotValid), .slotWarp(slotWarp), .activeQ(activeQ),
    .pendingQ(pendingQ), .strobe(strobe), .issueWarp(issueWarp));

  wsched_dp #(.NUM_WARPS(NUM_WARPS), .ACTIVE_SLOTS(ACTIVE_SLOTS),
              .WID_W(WID_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .issueWarp(issueWarp),
    .longDone(longDone), .longDoneId(longDoneId), .slotValid(slotValid),
    .slotWarp(slotWarp), .activeQ(activeQ), .pendingQ(pendingQ));

  assign issueValid   = strobe.issueEn;
  assign issueId      = issueWarp;
  assign evictValid   = strobe.demoteEn;
  assign evictId      = issueWarp;
  assign promoteValid = strobe.promoteEn;
  assign promoteId    = strobe.promoteWarp[WID_W-1:0];

  // R2: a granted warp has its ready flag high
  assert_issue_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> warpReady[issueId]);
  // R3: the previous issuer keeps the grant while ready
  assert_greedy_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(issueValid) && !$past(evictValid) && warpReady[$past(issueId)])
      |-> (issueValid && issueId == $past(issueId)));
  // R6: eviction accompanies a long-class grant of the same warp
  assert_evict_on_long_R6: assert property (@(posedge clk) disable iff (!rstN)
    evictValid |-> (issueValid && evictId == issueId && warpLongOp[issueId]));
  // R6: an evicted warp is not granted in the following cycle
  assert_evicted_gone_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(evictValid) |-> !(issueValid && issueId == $past(evictId)));
  // R9: the warp evicted this cycle is not the one promoted
  assert_no_bounce_R9: assert property (@(posedge clk) disable iff (!rstN)
    (evictValid && promoteValid) |-> (evictId != promoteId));
endmodule

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;
  localparam int NW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NW-1:0] warpReady = '0;
  logic [NW-1:0] warpLongOp = '0;
  logic          longDone = 1'b0;
  logic [3:0]    longDoneId = '0;
  logic          issueValid, evictValid, promoteValid;
  logic [3:0]    issueId, evictId, promoteId;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .ACTIVE_SLOTS(6)) u0 (
    .clk(clk), .rstN(rstN), .warpReady(warpReady), .warpLongOp(warpLongOp),
    .longDone(longDone), .longDoneId(longDoneId), .issueValid(issueValid),
    .issueId(issueId), .evictValid(evictValid), .evictId(evictId),
    .promoteValid(promoteValid), .promoteId(promoteId));

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    repeat (3) step();
    #3;
    chk("R1 no grant in reset", !issueValid, issueValid, 0);
    chk("R1 no promote in reset", !promoteValid, promoteValid, 0);
    rstN = 1'b1;
    #1;
    chk("R1 first promote warp0", promoteValid && promoteId == 0, promoteId, 0);
    chk("R1 no grant with empty pool", !issueValid, issueValid, 0);
    step();
    for (int k = 1; k < 6; k++) begin
      #3;
      chk("R1 fill order", promoteValid && promoteId == k, promoteId, k);
      step();
    end
    #3;
    chk("R1 fill stops when full", !promoteValid, promoteValid, 0);
  endtask

  task automatic testGreedy();
    warpReady = 16'h003F;
    #3;
    chk("R4 lowest slot wins", issueValid && issueId == 0, issueId, 0);
    step();
    #3;
    chk("R3 holder keeps grant", issueValid && issueId == 0, issueId, 0);
    step();
    warpReady = 16'h003E;
    #3;
    chk("R4 next lowest on stall", issueValid && issueId == 1, issueId, 1);
    step();
    warpReady = 16'h003F;
    #3;
    chk("R3 no return to warp0", issueValid && issueId == 1, issueId, 1);
    step();
  endtask

  task automatic testOuterIgnored();
    warpReady = 16'h0400;
    #3;
    chk("R2 outer-pool warp not granted", !issueValid, issueValid, 0);
    step();
  endtask

  task automatic testShortStall();
    bit bad = 1'b0;
    warpReady = '0;
    for (int c = 0; c < 22; c++) begin
      #3;
      if (issueValid || evictValid || promoteValid) bad = 1'b1;
      step();
    end
    chk("R5 quiet during short stall", !bad, bad, 0);
    warpReady = 16'h0002;
    #3;
    chk("R5 warp1 still active", issueValid && issueId == 1 && !evictValid, issueId, 1);
    step();
  endtask

  task automatic testDemote();
    warpReady  = 16'h0002;
    warpLongOp = 16'h0002;
    #3;
    chk("R6 long grant", issueValid && issueId == 1, issueId, 1);
    chk("R6 evict pulse id", evictValid && evictId == 1, evictId, 1);
    chk("R9 no promote into full pool", !promoteValid, promoteValid, 0);
    step();
    warpLongOp = '0;
    #3;
    chk("R6 evicted warp not granted", !issueValid, issueValid, 0);
    chk("R7 refill with warp6", promoteValid && promoteId == 6, promoteId, 6);
    step();
    #3;
    chk("R7 pool full again", !promoteValid, promoteValid, 0);
  endtask

  task automatic testComplete();
    warpReady  = '0;
    longDone   = 1'b1;
    longDoneId = 4'd1;
    step();
    longDone   = 1'b0;
    warpReady  = 16'h0004;
    warpLongOp = 16'h0004;
    #3;
    chk("R6 evict warp2", evictValid && evictId == 2, evictId, 2);
    step();
    warpLongOp = '0;
    #3;
    chk("R6 warp2 gone", !issueValid, issueValid, 0);
    chk("R8 completed warp1 promoted", promoteValid && promoteId == 1, promoteId, 1);
    step();
    warpReady = 16'h0002;
    #3;
    chk("R8 warp1 issues again", issueValid && issueId == 1, issueId, 1);
    step();
    warpReady = 16'h0004;
    #3;
    chk("R8 waiting warp2 not granted", !issueValid, issueValid, 0);
    step();
  endtask

  initial begin
    testReset();
    testGreedy();
    testOuterIgnored();
    testShortStall();
    testDemote();
    testComplete();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule